// File: doc/BRIEF.md
# Privileged Stack Pointer Fetcher

This block finds the stack selector and stack pointer that a task keeps for an inner privilege level (0, 1 or 2). It works from the task-state segment that the current task register points to. The caller presents a request with the target level and the task register contents: selector, descriptor type, base and limit. The block first checks that the slot lies inside the segment. It then reads the stack pointer and, after that, the stack selector through a simple request/acknowledge memory port. It reports the result, a task-state fault with its error code, or an internal error.

The slot layout depends on the width of the task. A 32-bit busy task holds a dword pointer followed by a word selector in 8-byte slots. A 16-bit busy task holds a word pointer followed by a word selector in 4-byte slots. The block does not decide whether a privilege change is needed, and it does not load the stack segment. Both remain with the caller.

The controller steps through five named states. IDLE goes to CHECK on an accepted request. CHECK goes to READ_SP when the type, level and bounds are good, and goes straight to REPORT on a fault or an error. READ_SP goes to READ_SEL on acknowledge. READ_SEL goes to REPORT on acknowledge. REPORT returns to IDLE after one cycle.

Top module: `spf_fetch`

## Requirements
- R1: After reset, `done`, `busy` and `mem_req` are low, and `ok`, `fault`, `err`, `new_sp` and `new_ss` read zero.
- R2: For a task of type code 4'hB (32-bit busy), the slot offset is level×8+4. The first access is a dword read (`mem_dword`=1) at base+offset. Its full 32 bits become `new_sp`.
- R3: For type 4'hB, the second access is a word read (`mem_dword`=0) at base+offset+4. Bits [15:0] of its data become `new_ss`.
- R4: For type 4'hB, the request ends with `fault` and no memory access when offset+7 exceeds the limit. When offset+7 equals the limit, the request completes normally.
- R5: For a task of type code 4'h3 (16-bit busy), the slot offset is level×4+2. The first access is a word read at base+offset, and `new_sp` is its bits [15:0] zero-extended. The second access is a word read at base+offset+2 that gives `new_ss`.
- R6: For type 4'h3, the request ends with `fault` and no memory access when offset+3 exceeds the limit. When offset+3 equals the limit, the request completes normally.
- R7: On a fault, `fault_code` equals the task register selector with bits [1:0] forced to zero.
- R8: Any type code other than 4'h3 or 4'hB ends the request with `err` and no memory access.
- R9: A target level of 3 ends the request with `err` and no memory access.
- R10: A memory request holds its address and size stable until `mem_ack`, for any acknowledge latency. Address arithmetic wraps modulo 2^32.
- R11: `done` pulses for exactly one cycle per request, with exactly one of `ok`, `fault`, `err` high. `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a lookup (accepted when not busy) |
| req_pl | input | 2 | Target privilege level |
| tr_sel | input | 16 | Task register selector |
| tr_type | input | 4 | Task register descriptor type code |
| tr_base | input | 32 | Task-state segment base |
| tr_limit | input | 32 | Task-state segment limit |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_dword | output | 1 | 1 = dword read, 0 = word read |
| mem_ack | input | 1 | Read data valid, request complete |
| mem_rdata | input | 32 | Read data (word reads use bits [15:0]) |
| busy | output | 1 | A lookup is in progress |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Last lookup returned a stack |
| fault | output | 1 | Last lookup raised a task-state fault |
| fault_code | output | 16 | Fault error code |
| err | output | 1 | Last lookup had an invalid type or level |
| new_ss | output | 16 | Fetched stack selector |
| new_sp | output | 32 | Fetched stack pointer |

## Verification
The hardest case to reach from the ports is a request that arrives while the block waits on a slow memory. The bench stretches the acknowledge latency and keeps `req_valid` high with different values during that wait. The result must still belong to the first request. The exact-limit boundaries for both task widths are also narrow. The vector table places the slot end one byte past the limit and exactly on it, and the responder's access log confirms that a fault touched no memory.

// File: rtl/spf_pkg.sv
package spf_pkg;
    localparam logic [3:0] TYPE_BUSY16 = 4'h3;
    localparam logic [3:0] TYPE_BUSY32 = 4'hB;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_READ_SP,
        S_READ_SEL,
        S_REPORT
    } spf_state_e;

    typedef enum logic [1:0] {
        ST_NONE,
        ST_OK,
        ST_FAULT,
        ST_ERR
    } spf_status_e;
endpackage

// File: rtl/spf_slot_calc.sv
module spf_slot_calc #(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        pl,
    input  logic [3:0]        ttype,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    output logic              type_ok,
    output logic              pl_ok,
    output logic              is32,
    output logic              in_bounds,
    output logic [ADDR_W-1:0] sp_addr,
    output logic [ADDR_W-1:0] sel_addr
);
    import spf_pkg::*;

    localparam int OFF_W = 8;

    logic              is16;
    logic [OFF_W-1:0]  off32, off16, slot_off, slot_end, sel_off;
    logic [ADDR_W-1:0] end_ext;

    always_comb begin
        is32     = (ttype == TYPE_BUSY32);
        is16     = (ttype == TYPE_BUSY16);
        type_ok  = is32 | is16;
        pl_ok    = (pl != 2'd3);
        off32    = {3'b000, pl, 3'b000} + OFF_W'(4);
        off16    = {4'b0000, pl, 2'b00} + OFF_W'(2);
        slot_off = is32 ? off32 : off16;
        slot_end = is32 ? (off32 + OFF_W'(7)) : (off16 + OFF_W'(3));
        sel_off  = is32 ? (off32 + OFF_W'(4)) : (off16 + OFF_W'(2));
        end_ext  = ADDR_W'(slot_end);
        in_bounds = (end_ext <= limit);
        sp_addr  = base + ADDR_W'(slot_off);
        sel_addr = base + ADDR_W'(sel_off);
    end
endmodule

// File: rtl/spf_ctrl.sv
module spf_ctrl (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                type_ok,
    input  logic                pl_ok,
    input  logic                in_bounds,
    input  logic                mem_ack,
    output spf_pkg::spf_state_e state,
    output logic                busy,
    output logic                done,
    output logic                mem_req,
    output logic                sel_phase,
    output logic                cap_req,
    output logic                cap_sp,
    output logic                cap_ss,
    output logic                set_fault,
    output logic                set_err
);
    import spf_pkg::*;

    spf_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = S_CHECK;
            S_CHECK:    state_d = (type_ok && pl_ok && in_bounds) ? S_READ_SP : S_REPORT;
            S_READ_SP:  if (mem_ack) state_d = S_READ_SEL;
            S_READ_SEL: if (mem_ack) state_d = S_REPORT;
            S_REPORT:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state_q != S_IDLE);
        done      = (state_q == S_REPORT);
        mem_req   = (state_q == S_READ_SP) || (state_q == S_READ_SEL);
        sel_phase = (state_q == S_READ_SEL);
        cap_req   = (state_q == S_IDLE) && req_valid;
        cap_sp    = (state_q == S_READ_SP) && mem_ack;
        cap_ss    = (state_q == S_READ_SEL) && mem_ack;
        set_err   = (state_q == S_CHECK) && !(type_ok && pl_ok);
        set_fault = (state_q == S_CHECK) && type_ok && pl_ok && !in_bounds;
    end

    assign state = state_q;

    // R4 / R6 / R8 / R9: a rejected lookup never reaches the memory port
    a_r6_no_access_after_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && !(type_ok && pl_ok && in_bounds)) |=> !mem_req);

    // R3: the selector read only follows an acknowledged pointer read
    a_r3_sel_after_sp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_phase) |-> $past(mem_ack));

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/spf_datapath.sv
module spf_datapath #(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_req,
    input  logic              cap_sp,
    input  logic              cap_ss,
    input  logic              set_fault,
    input  logic              set_err,
    input  logic              is32,
    input  logic [1:0]        req_pl,
    input  logic [SEL_W-1:0]  tr_sel,
    input  logic [3:0]        tr_type,
    input  logic [ADDR_W-1:0] tr_base,
    input  logic [ADDR_W-1:0] tr_limit,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [1:0]        q_pl,
    output logic [3:0]        q_type,
    output logic [ADDR_W-1:0] q_base,
    output logic [ADDR_W-1:0] q_limit,
    output logic              ok,
    output logic              fault,
    output logic              err,
    output logic [SEL_W-1:0]  fault_code,
    output logic [SEL_W-1:0]  new_ss,
    output logic [DATA_W-1:0] new_sp
);
    import spf_pkg::*;

    localparam int WORD_W = 16;

    logic [SEL_W-1:0]  q_sel;
    spf_status_e       status_q;
    logic [DATA_W-1:0] sp_word;

    always_comb begin
        sp_word = '0;
        sp_word[WORD_W-1:0] = mem_rdata[WORD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_pl     <= '0;
            q_type   <= '0;
            q_base   <= '0;
            q_limit  <= '0;
            q_sel    <= '0;
            status_q <= ST_NONE;
            new_ss   <= '0;
            new_sp   <= '0;
        end else begin
            if (cap_req) begin
                q_pl     <= req_pl;
                q_type   <= tr_type;
                q_base   <= tr_base;
                q_limit  <= tr_limit;
                q_sel    <= tr_sel;
                status_q <= ST_NONE;
            end
            if (set_err)   status_q <= ST_ERR;
            if (set_fault) status_q <= ST_FAULT;
            if (cap_sp)    new_sp   <= is32 ? mem_rdata : sp_word;
            if (cap_ss) begin
                new_ss   <= mem_rdata[SEL_W-1:0];
                status_q <= ST_OK;
            end
        end
    end

    always_comb begin
        ok         = (status_q == ST_OK);
        fault      = (status_q == ST_FAULT);
        err        = (status_q == ST_ERR);
        fault_code = {q_sel[SEL_W-1:2], 2'b00};
    end

    // R5: a 16-bit pointer capture clears the upper half
    a_r5_sp_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_sp && !is32) |=> (new_sp[DATA_W-1:WORD_W] == '0));
endmodule

// File: rtl/spf_fetch.sv
module spf_fetch #(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_pl,
    input  logic [SEL_W-1:0]  tr_sel,
    input  logic [3:0]        tr_type,
    input  logic [ADDR_W-1:0] tr_base,
    input  logic [ADDR_W-1:0] tr_limit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_dword,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic              fault,
    output logic [SEL_W-1:0]  fault_code,
    output logic              err,
    output logic [SEL_W-1:0]  new_ss,
    output logic [DATA_W-1:0] new_sp
);
    import spf_pkg::*;

    spf_state_e        state;
    logic              type_ok, pl_ok, is32, in_bounds;
    logic [ADDR_W-1:0] sp_addr, sel_addr;
    logic              sel_phase, cap_req, cap_sp, cap_ss, set_fault, set_err;
    logic [1:0]        q_pl;
    logic [3:0]        q_type;
    logic [ADDR_W-1:0] q_base, q_limit;

    spf_slot_calc #(.ADDR_W(ADDR_W)) calc_i (
        .pl(q_pl), .ttype(q_type), .base(q_base), .limit(q_limit),
        .type_ok(type_ok), .pl_ok(pl_ok), .is32(is32), .in_bounds(in_bounds),
        .sp_addr(sp_addr), .sel_addr(sel_addr)
    );

    spf_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .type_ok(type_ok), .pl_ok(pl_ok), .in_bounds(in_bounds), .mem_ack(mem_ack),
        .state(state), .busy(busy), .done(done), .mem_req(mem_req),
        .sel_phase(sel_phase), .cap_req(cap_req), .cap_sp(cap_sp), .cap_ss(cap_ss),
        .set_fault(set_fault), .set_err(set_err)
    );

    spf_datapath #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .DATA_W(DATA_W)) dp_i (
        .clk(clk), .rst_n(rst_n), .cap_req(cap_req), .cap_sp(cap_sp), .cap_ss(cap_ss),
        .set_fault(set_fault), .set_err(set_err), .is32(is32),
        .req_pl(req_pl), .tr_sel(tr_sel), .tr_type(tr_type),
        .tr_base(tr_base), .tr_limit(tr_limit), .mem_rdata(mem_rdata),
        .q_pl(q_pl), .q_type(q_type), .q_base(q_base), .q_limit(q_limit),
        .ok(ok), .fault(fault), .err(err), .fault_code(fault_code),
        .new_ss(new_ss), .new_sp(new_sp)
    );

    always_comb begin
        mem_addr  = sel_phase ? sel_addr : sp_addr;
        mem_dword = !sel_phase && is32;
    end

    // R10: a pending request keeps its address and size until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_dword)));

    // R11: exactly one status flag accompanies completion
    a_r11_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({ok, fault, err}));

    // R7: a fault code never carries requestor-privilege bits
    a_r7_code_rpl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_code[1:0] == 2'b00));

    // R11: the request inputs are not sampled during a lookup
    a_r11_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != S_REPORT) |=> busy);
endmodule

// File: tb/spf_fetch_tb.sv
module spf_fetch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    typedef struct packed {
        logic [1:0]  pl;
        logic [3:0]  ttype;
        logic [31:0] base;
        logic [31:0] limit;
        logic [15:0] sel;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 4'hB, 32'h0000_1000, 32'h0000_0067, 16'h002B},
        '{2'd2, 4'hB, 32'h2000_0000, 32'h0000_0067, 16'h0010},
        '{2'd2, 4'hB, 32'h0000_3000, 32'd26,        16'h0033},
        '{2'd2, 4'hB, 32'h0000_3000, 32'd27,        16'h0033},
        '{2'd1, 4'h3, 32'h0000_0500, 32'h0000_002B, 16'h0019},
        '{2'd2, 4'h3, 32'h0000_0700, 32'd12,        16'h0047},
        '{2'd2, 4'h3, 32'h0000_0700, 32'd13,        16'h0047},
        '{2'd0, 4'h9, 32'h0000_0800, 32'h0000_0067, 16'h0020},
        '{2'd3, 4'hB, 32'h0000_0900, 32'h0000_0FFF, 16'h0028},
        '{2'd0, 4'h3, 32'hFFFF_FFFE, 32'h0000_002B, 16'h003A}
    };

    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [1:0] req_pl = 0;
    logic [15:0] tr_sel = 0;
    logic [3:0] tr_type = 0;
    logic [31:0] tr_base = 0, tr_limit = 0;
    logic mem_req, mem_dword, mem_ack = 0;
    logic [31:0] mem_addr, mem_rdata = 0;
    logic busy, done, ok, fault, err;
    logic [15:0] fault_code, new_ss;
    logic [31:0] new_sp;

    int checks = 0, fails = 0;
    int lat = 0, cnt = 0, acc_n = 0;
    logic [31:0] acc_addr [4];
    logic        acc_dw   [4];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spf_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pl(req_pl),
        .tr_sel(tr_sel), .tr_type(tr_type), .tr_base(tr_base), .tr_limit(tr_limit),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_dword(mem_dword),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .ok(ok), .fault(fault), .fault_code(fault_code), .err(err),
        .new_ss(new_ss), .new_sp(new_sp)
    );

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {~a[15:0], a[15:0] ^ 16'h5A3C};
    endfunction

    // memory responder, acts on falling edges
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 0;
            cnt = 0;
        end else if (rst_n && mem_req) begin
            if (cnt >= lat) begin
                mem_rdata = mem_val(mem_addr);
                mem_ack = 1;
                acc_addr[acc_n % 4] = mem_addr;
                acc_dw[acc_n % 4] = mem_dword;
                acc_n = acc_n + 1;
                cnt = 0;
            end else cnt = cnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        if (!done) check("R11 done timeout", 0, 1);
    endtask

    task automatic run_vec(input vec_t v, input bit hold_noise);
        int start_n;
        bit is32, is16, legal, inb;
        logic [31:0] off, lastb, a_sp, a_ss, exp_sp;
        @(negedge clk);
        start_n = acc_n;
        req_pl = v.pl; tr_type = v.ttype; tr_base = v.base;
        tr_limit = v.limit; tr_sel = v.sel; req_valid = 1;
        @(negedge clk);
        if (hold_noise) begin
            req_pl = 2'd0; tr_base = 32'hDEAD_0000; tr_sel = 16'h00FF;
        end else req_valid = 0;
        // expected values
        is32  = (v.ttype == 4'hB);
        is16  = (v.ttype == 4'h3);
        legal = (is32 || is16) && (v.pl != 2'd3);
        off   = is32 ? (32'(v.pl) * 8 + 4) : (32'(v.pl) * 4 + 2);
        lastb = is32 ? off + 7 : off + 3;
        inb   = (lastb <= v.limit);
        a_sp  = v.base + off;
        a_ss  = v.base + off + (is32 ? 32'd4 : 32'd2);
        exp_sp = is32 ? mem_val(a_sp) : {16'h0, mem_val(a_sp)[15:0]};
        while (!done) begin
            @(negedge clk);
            if (hold_noise && busy && acc_n > start_n) req_valid = 0;
        end
        req_valid = 0;
        if (!legal) begin
            check(is32 || is16 ? "R9 err on level 3" : "R8 err on bad type", {31'b0, err}, 1);
            check("R8/R9 no access", acc_n - start_n, 0);
        end else if (!inb) begin
            check(is32 ? "R4 fault flag" : "R6 fault flag", {31'b0, fault}, 1);
            check("R7 fault code", {16'h0, fault_code}, {16'h0, v.sel & 16'hFFFC});
            check(is32 ? "R4 no access" : "R6 no access", acc_n - start_n, 0);
        end else begin
            check("R11 ok flag", {29'b0, ok, fault, err}, 32'b100);
            check(is32 ? "R2 sp value" : "R5 sp zero-ext", new_sp, exp_sp);
            check(is32 ? "R3 ss value" : "R5 ss value", {16'h0, new_ss}, {16'h0, mem_val(a_ss)[15:0]});
            check("R10 access count", acc_n - start_n, 2);
            check(is32 ? "R2 sp addr" : "R5 sp addr", acc_addr[start_n % 4], a_sp);
            check(is32 ? "R2 dword size" : "R5 word size", {31'b0, acc_dw[start_n % 4]}, {31'b0, is32});
            check(is32 ? "R3 ss addr" : "R5 ss addr", acc_addr[(start_n + 1) % 4], a_ss);
            check("R3 ss word size", {31'b0, acc_dw[(start_n + 1) % 4]}, 0);
        end
        @(negedge clk);
        check("R11 done single cycle", {31'b0, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", {31'b0, done}, 0);
        check("R1 busy", {31'b0, busy}, 0);
        check("R1 mem_req", {31'b0, mem_req}, 0);
        check("R1 status", {29'b0, ok, fault, err}, 0);
        check("R1 sp/ss", new_sp | {16'h0, new_ss}, 0);
        rst_n = 1;
        for (int i = 0; i < NVEC; i++) begin
            lat = i % 3;
            run_vec(VECS[i], 0);
        end
        // R11: request inputs changing and valid held high during a slow fetch
        lat = 5;
        run_vec(VECS[1], 1);
        // R10: long latency on a 16-bit task
        lat = 9;
        run_vec(VECS[4], 0);
        lat = 0;
        run_vec(VECS[9], 0);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule